// File: doc/BRIEF.md
# GF(2^128) Montgomery Folding Reducer

This block takes a 256-bit carry-less product and reduces it to a 128-bit field element. The field polynomial is g(x) = x^128 + x^127 + x^126 + x^121 + 1. The reduction is Montgomery style: the output is P·x^-128 mod g(x). When P comes from a carry-less multiplier fed with a and b, the output is the field product a·b·x^-128. Computing the product and preparing key powers happen outside this block.

The reduction does not divide. It uses the 64-bit constant c = x^63 + x^62 + x^57, which is the middle part of g, so that g = x^128 + c·x^64 + 1. It then cancels the input 64 bits at a time, starting from the bottom:

- **First fold.** The lowest quarter of P is multiplied by c. The two halves of that 128-bit product are swapped. The swapped value is XORed into the low half of P, and that sum is XORed into the high half.
- **Second fold.** The upper quarter of the first-fold sum is multiplied by c and XORed into the updated high half.

After both folds the low 128 bits are zero, and the field element is in the upper half.

Each fold occupies one pipeline stage. A valid bit travels alongside the data, so one new product can enter on every cycle.

Top module: `gf128_fold_reducer`

## Requirements
- R1: While rst_n is low, and on the first sample after it is released, out_valid is 0 and out_data is all zeros.
- R2: Each cycle in which in_valid is 1 produces exactly one out_valid pulse, two rising clock edges later. out_valid is 0 in every cycle that does not correspond to an accepted input.
- R3: For an accepted input, out_data equals prod_in·x^-128 mod g(x). Bit i of prod_in and of out_data is the coefficient of x^i. The result is the unique remainder, of degree below 128.
- R4: If bits 127..0 of the input are zero, out_data equals bits 255..128 of that input.
- R5: An input that is a multiple of g(x) gives a result of zero. Examples are g itself and g·x^k for k from 0 to 127.
- R6: In a cycle in which out_valid is 0, out_data keeps its previous value. prod_in has no effect while in_valid is 0.
- R7: Inputs may be presented on consecutive cycles. Every one of them yields its own correct result, in order.
- R8: Asserting rst_n low discards inputs that are still in flight. No result for them appears after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | prod_in carries a product to reduce |
| prod_in | input | 256 | Carry-less product; bit i is the coefficient of x^i |
| out_valid | output | 1 | out_data carries a new result |
| out_data | output | 128 | Reduced value prod_in·x^-128 mod g |

## Verification
The hardest case to reach is an input whose low part makes the first fold's upper quarter land exactly on the bits that the second fold must cancel. Random 256-bit words seldom hit the cancellation edges, meaning inputs equal to g·x^k, where every folded term must vanish. The stimulus therefore walks g through all 128 shifts, and it also feeds products with an all-zero low half, all-ones words and single-bit words. Long back-to-back random bursts, interleaved with idle gaps, expose any data that leaks from one stage into the next.

// File: rtl/gf128_fold_reducer.sv
module gf128_fold_reducer #(
  parameter int HALF = 64,
  parameter logic [HALF-1:0] FOLD_CONST = 64'hC200_0000_0000_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [4*HALF-1:0]   prod_in,
  output logic                out_valid,
  output logic [2*HALF-1:0]   out_data
);
  localparam int FULL = 2 * HALF;
  localparam int WIDE = 4 * HALF;

  function automatic logic [FULL-1:0] clmul(input logic [HALF-1:0] a, input logic [HALF-1:0] b);
    logic [FULL-1:0] acc;
    acc = '0;
    for (int i = 0; i < HALF; i++)
      if (b[i]) acc ^= FULL'(a) << i;
    return acc;
  endfunction

  // first fold: cancel the lowest quarter
  logic [FULL-1:0] f1_prod, f1_swap, f1_mid, f1_hi;
  assign f1_prod = clmul(prod_in[HALF-1:0], FOLD_CONST);
  assign f1_swap = {f1_prod[HALF-1:0], f1_prod[FULL-1:HALF]};
  assign f1_mid  = prod_in[FULL-1:0] ^ f1_swap;
  assign f1_hi   = prod_in[WIDE-1:FULL] ^ f1_mid;

  logic            s1_valid;
  logic [FULL-1:0] s1_hi;
  logic [HALF-1:0] s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_hi    <= '0;
      s1_q     <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_hi <= f1_hi;
        s1_q  <= f1_mid[FULL-1:HALF];
      end
    end
  end

  // second fold: cancel the next quarter
  logic [FULL-1:0] f2_prod;
  assign f2_prod = clmul(s1_q, FOLD_CONST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_data <= s1_hi ^ f2_prod;
    end
  end
endmodule

module gf128_fold_reducer_chk #(
  parameter int HALF = 64,
  parameter logic [HALF-1:0] FOLD_CONST = 64'hC200_0000_0000_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [4*HALF-1:0] prod_in,
  input logic              out_valid,
  input logic [2*HALF-1:0] out_data
);
  localparam int FULL = 2 * HALF;
  localparam int WIDE = 4 * HALF;
  localparam logic [WIDE-1:0] G_POLY =
    (WIDE'(1) << FULL) | (WIDE'(FOLD_CONST) << HALF) | WIDE'(1);

  p_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
  p_lowzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && prod_in[FULL-1:0] == '0) |=> ##1 (out_data == $past(prod_in[WIDE-1:FULL], 2)));
  p_modulus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && prod_in == G_POLY) |=> ##1 (out_data == '0));
endmodule

bind gf128_fold_reducer gf128_fold_reducer_chk #(.HALF(HALF), .FOLD_CONST(FOLD_CONST)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .prod_in(prod_in),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sim_gf128_fold_reducer.sv
module sim_gf128_fold_reducer;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [255:0] prod_in = '0;
  logic         out_valid;
  logic [127:0] out_data;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  logic         e1v = 1'b0, e2v = 1'b0;
  logic [127:0] e1d = '0, e2d = '0;

  gf128_fold_reducer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .prod_in(prod_in),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  localparam logic [256:0] G257 = (257'd1 << 128) | (257'd1 << 127) | (257'd1 << 126) | (257'd1 << 121) | 257'd1;

  function automatic logic [127:0] ref_reduce(input logic [255:0] p);
    logic [256:0] r;
    r = {1'b0, p};
    for (int k = 0; k < 128; k++) begin
      if (r[0]) r = r ^ G257;
      r = r >> 1;
    end
    return r[127:0];
  endfunction

  function automatic logic [255:0] rand256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s out_valid actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic check_data(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s out_data actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; drives, advances the model, checks at the next falling edge
  task automatic step(input logic v, input logic [255:0] p, input string tag);
    in_valid = v;
    prod_in  = p;
    @(posedge clk);
    if (e1v) e2d = e1d;
    e2v = e1v;
    e1v = v;
    if (v) e1d = ref_reduce(p);
    @(negedge clk);
    check_bit(tag, out_valid, e2v);
    check_data(tag, out_data, e2d);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check_bit("R1", out_valid, 1'b0);
    check_data("R1", out_data, '0);
    e1v = 1'b0; e2v = 1'b0; e1d = '0; e2d = '0;
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R1", out_valid, 1'b0);
    check_data("R1", out_data, '0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [255:0] gw;
    void'($urandom(32'd1234));
    @(negedge clk);
    apply_reset();

    // R3 directed values
    step(1'b1, '0, "R3");
    step(1'b1, {256{1'b1}}, "R3");
    step(1'b1, 256'd1, "R3");
    step(1'b1, 256'd1 << 255, "R3");
    // R4 low half zero
    step(1'b1, 256'd1 << 128, "R4");
    step(1'b1, {rand256() >> 128, 128'd0} | 256'd0, "R4");
    step(1'b1, {rand256() >> 128, 128'd0} | 256'd0, "R4");
    // R5 multiples of g
    gw = G257[255:0];
    for (int k = 0; k < 128; k++) step(1'b1, gw << k, "R5");
    step(1'b0, '0, "R5");
    step(1'b0, '0, "R5");

    // R6 idle with changing inputs
    for (int i = 0; i < 20; i++) step(1'b0, rand256(), "R6");

    // R7 back-to-back random
    for (int i = 0; i < 300; i++) step(1'b1, rand256(), "R7");

    // R2/R3 random with gaps
    for (int i = 0; i < 600; i++) step(($urandom % 3) != 0, rand256(), "R2");
    step(1'b0, '0, "R2");
    step(1'b0, '0, "R2");

    // R8 reset with data in flight
    step(1'b1, rand256(), "R8");
    in_valid = 1'b1;
    prod_in  = rand256();
    @(posedge clk);
    @(negedge clk);
    apply_reset();
    for (int i = 0; i < 4; i++) step(1'b0, rand256(), "R8");
    step(1'b1, rand256(), "R8");
    step(1'b0, '0, "R8");
    step(1'b0, '0, "R8");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule